// File: doc/BRIEF.md
# Read Fast-Start and Address-Mark Gap Sequencer

This block decides when the read-clock recovery loop runs in its high-gain acquisition mode. That mode is called fast start here. Its inputs are a read-enable level, a read command, a read-header command, and two single-cycle data-pulse strobes, one early and one delayed. All of its timing is counted in system-clock cycles. The lengths are derived from nanosecond parameters and a cycles-per-microsecond parameter.

There are two ways fast start begins:

- A rising edge on the read command opens a window of about 5 µs.
- A quiet stretch with no data pulses, lasting about two byte-times of 1.24 µs each, marks the gap ahead of an address mark. The first pulse after that stretch opens the window again and emits a one-cycle resync strobe.

While the window is open, the deserializer must not accept data. A data-good qualifier rises on the clock edge that closes the window. It stays high until read enable drops or a new window opens. Dropping read enable returns every timer and output to idle.

Top module: `fs_seq_top`

## Requirements
- R1: After a synchronous reset, fast_start, resync and data_good are all low.
- R2: With rd_en high, a rising edge on rd_cmd raises fast_start at that clock edge. fast_start then stays high for exactly FS_CYC cycles, where FS_CYC = (CYC_PER_US*FS_NS+500)/1000. A new rd_cmd edge inside the window restarts the full length.
- R3: A window opened by rd_cmd never produces a resync pulse.
- R4: A rising edge on rd_hdr_cmd without a rising edge on rd_cmd changes none of fast_start, resync or data_good.
- R5: The gap detector counts consecutive clock edges that have rd_en high and no pulse on early_pulse or late_pulse. It arms once that count reaches GAP_CYC = GAP_BYTES*BYTE_CYC, where BYTE_CYC = (CYC_PER_US*BYTE_NS+500)/1000. Any pulse restarts the count.
- R6: When the detector is armed, the next pulse raises fast_start at that edge. The same edge raises resync, which stays high for exactly one cycle.
- R7: A quiet run shorter than GAP_CYC edges, followed by a pulse, opens no window and gives no resync.
- R8: data_good rises on the edge where the window closes, so it is never high together with fast_start. It stays high until rd_en drops or a new window opens, and a new window clears it on the same edge.
- R9: One clock edge with rd_en low forces all three outputs low and clears the gap count. rd_cmd edges seen while rd_en is low are ignored. A rd_cmd held high across the rise of rd_en does not open a window.
- R10: early_pulse and late_pulse act identically. Pulses inside an open window neither lengthen nor shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable level; low holds the block idle |
| rd_cmd | input | 1 | Read command level; its rising edge opens a window |
| rd_hdr_cmd | input | 1 | Read-header command level; opens no window |
| early_pulse | input | 1 | One-cycle strobe for an early data pulse |
| late_pulse | input | 1 | One-cycle strobe for a delayed data pulse |
| fast_start | output | 1 | High during the acquisition window |
| resync | output | 1 | One-cycle strobe when a gap-triggered window opens |
| data_good | output | 1 | Qualifies deserializer data after a window closes |

## Verification
Every output is a register fed directly by the inputs at the same edge, so each result is due one edge after its stimulus:

- A command edge or a post-gap pulse is visible on fast_start and resync right after that edge.
- data_good is visible after the edge that is FS_CYC edges later.
- The gap arms after exactly GAP_CYC quiet edges, so a pulse on quiet edge GAP_CYC+1 fires.

The bench applies each input just after a rising edge and reads the outputs one time unit after the next rising edge, so every check sees exactly the edge that consumed its stimulus. Quiet-gap lengths are swept around GAP_CYC. The window length is measured by counting high cycles, and both are compared with values computed from the parameters.

// File: rtl/fs_seq_pkg.sv
package fs_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_READ = 2'd1,
    CMD_HDR  = 2'd2
  } cmd_kind_e;

  // Convert a duration in ns to clock cycles, rounded to nearest.
  function automatic int ns_to_cyc(input int cyc_per_us, input int ns);
    return (cyc_per_us * ns + 500) / 1000;
  endfunction

endpackage

// File: rtl/fs_cmd_front.sv
module fs_cmd_front
  import fs_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_en,
  input  logic      rd_cmd,
  input  logic      rd_hdr_cmd,
  input  logic      early_pulse,
  input  logic      late_pulse,
  output cmd_kind_e kind,
  output logic      pulse
);

  logic rd_cmd_q;
  logic hdr_cmd_q;
  logic rd_rise;
  logic hdr_rise;

  // Edge history tracks the levels even while rd_en is low, so a command
  // held across the rise of rd_en is not mistaken for a new one.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cmd_q  <= 1'b0;
      hdr_cmd_q <= 1'b0;
    end else begin
      rd_cmd_q  <= rd_cmd;
      hdr_cmd_q <= rd_hdr_cmd;
    end
  end

  assign rd_rise  = rd_cmd & ~rd_cmd_q;
  assign hdr_rise = rd_hdr_cmd & ~hdr_cmd_q;

  // A read edge wins over a simultaneous header edge.
  always_comb begin
    kind = CMD_NONE;
    if (rd_en) begin
      if (rd_rise)       kind = CMD_READ;
      else if (hdr_rise) kind = CMD_HDR;
    end
  end

  assign pulse = early_pulse | late_pulse;

endmodule

// File: rtl/fs_gap_timer.sv
module fs_gap_timer #(
  parameter int GAP_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic pulse,
  output logic armed,
  output logic fire
);

  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      quiet_cnt <= '0;
      armed     <= 1'b0;
    end else if (pulse) begin
      quiet_cnt <= '0;
      armed     <= 1'b0;
    end else if (!armed) begin
      if (quiet_cnt == LAST) armed <= 1'b1;
      else                   quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign fire = armed & pulse & rd_en;

  AST_GAP_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt <= LAST); // R5

  AST_GAP_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed); // R6

  AST_GAP_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    pulse |=> (quiet_cnt == '0)); // R5

endmodule

// File: rtl/fs_window.sv
module fs_window #(
  parameter int FS_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic start,
  output logic active,
  output logic ending
);

  localparam int CW = $clog2(FS_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FS_CYC - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      active <= 1'b0;
      left   <= '0;
    end else if (start) begin
      active <= 1'b1;
      left   <= LAST;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - 1'b1;
    end
  end

  assign ending = active & (left == '0) & ~start & rd_en;

  AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (active && rd_en && !start && left != '0) |=> active); // R2

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    left <= LAST); // R2

endmodule

// File: rtl/fs_seq_top.sv
module fs_seq_top
  import fs_seq_pkg::*;
#(
  parameter int CYC_PER_US = 20,
  parameter int FS_NS      = 5000,
  parameter int BYTE_NS    = 1240,
  parameter int GAP_BYTES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic rd_cmd,
  input  logic rd_hdr_cmd,
  input  logic early_pulse,
  input  logic late_pulse,
  output logic fast_start,
  output logic resync,
  output logic data_good
);

  localparam int FS_CYC   = ns_to_cyc(CYC_PER_US, FS_NS);
  localparam int BYTE_CYC = ns_to_cyc(CYC_PER_US, BYTE_NS);
  localparam int GAP_CYC  = GAP_BYTES * BYTE_CYC;

  cmd_kind_e kind;
  logic      pulse;
  logic      gap_armed;
  logic      gap_fire;
  logic      launch_cmd;
  logic      start;
  logic      win_ending;

  fs_cmd_front u_front (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_cmd      (rd_cmd),
    .rd_hdr_cmd  (rd_hdr_cmd),
    .early_pulse (early_pulse),
    .late_pulse  (late_pulse),
    .kind        (kind),
    .pulse       (pulse)
  );

  fs_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .pulse (pulse),
    .armed (gap_armed),
    .fire  (gap_fire)
  );

  assign launch_cmd = (kind == CMD_READ);
  assign start      = launch_cmd | gap_fire;

  fs_window #(.FS_CYC(FS_CYC)) u_win (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .start  (start),
    .active (fast_start),
    .ending (win_ending)
  );

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      resync    <= 1'b0;
      data_good <= 1'b0;
    end else begin
      resync <= gap_fire;
      if (start)           data_good <= 1'b0;
      else if (win_ending) data_good <= 1'b1;
    end
  end

  AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!fast_start && !resync && !data_good)); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(fast_start && data_good)); // R8

  AST_RESYNC_IN_WIN: assert property (@(posedge clk) disable iff (rst)
    resync |-> fast_start); // R6

  AST_RESYNC_ONE: assert property (@(posedge clk) disable iff (rst)
    resync |=> !resync); // R6

  AST_DG_AFTER_WIN: assert property (@(posedge clk) disable iff (rst)
    $rose(data_good) |-> $past(fast_start)); // R8

  AST_CMD_NO_RESYNC: assert property (@(posedge clk) disable iff (rst)
    (launch_cmd && !gap_armed) |=> !resync); // R3

endmodule

// File: tb/sim_fs_seq_top.sv
module sim_fs_seq_top;

  localparam int CLK_P      = 10;
  localparam int CYC_PER_US = 4;
  localparam int FS_NS      = 5000;
  localparam int BYTE_NS    = 1240;
  localparam int GAP_BYTES  = 2;
  localparam int FS   = (CYC_PER_US * FS_NS + 500) / 1000;   // 20
  localparam int BYTE = (CYC_PER_US * BYTE_NS + 500) / 1000; // 5
  localparam int GAP  = GAP_BYTES * BYTE;                     // 10

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, rd_cmd = 1'b0, rd_hdr_cmd = 1'b0;
  logic early_pulse = 1'b0, late_pulse = 1'b0;
  logic fast_start, resync, data_good;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  fs_seq_top #(
    .CYC_PER_US(CYC_PER_US), .FS_NS(FS_NS), .BYTE_NS(BYTE_NS), .GAP_BYTES(GAP_BYTES)
  ) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_cmd(rd_cmd), .rd_hdr_cmd(rd_hdr_cmd),
    .early_pulse(early_pulse), .late_pulse(late_pulse),
    .fast_start(fast_start), .resync(resync), .data_good(data_good)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply pulses for one edge, then sample 1 unit after that edge.
  task automatic cyc(input logic e, input logic l);
    early_pulse = e;
    late_pulse  = l;
    @(posedge clk);
    #1;
    early_pulse = 1'b0;
    late_pulse  = 1'b0;
  endtask

  // Zeros pattern: a pulse every second cycle.
  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) cyc(i % 2 == 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1 fast_start", fast_start, 0);
    chk("R1 resync", resync, 0);
    chk("R1 data_good", data_good, 0);

    // Read command in a zeros stream.
    rd_en = 1'b1;
    zeros(4);
    rd_cmd = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R2 fast_start on cmd", fast_start, 1);
    chk("R3 no resync on cmd", resync, 0);
    begin
      int hi = 1;
      for (int i = 0; i < FS + 5; i++) begin
        cyc(i % 2 == 0, 1'b0);
        if (resync) chk("R3 resync in cmd window", resync, 0);
        if (fast_start) hi++;
        else break;
      end
      chk("R2 R10 window length", hi, FS);
      chk("R8 data_good at close", data_good, 1);
    end
    zeros(30);
    chk("R8 data_good holds", data_good, 1);

    // Header edge alone has no effect.
    rd_hdr_cmd = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc(i % 2 == 0, 1'b0);
      if (fast_start || resync || !data_good) chk("R4 hdr no effect", {fast_start, resync, data_good}, 3'b001);
    end
    chk("R4 hdr fast_start", fast_start, 0);
    chk("R4 hdr data_good", data_good, 1);
    rd_hdr_cmd = 1'b0;

    // Gap sweep around GAP (includes 2.5 byte-times).
    for (int n = GAP - 3; n <= GAP + 3; n++) begin
      int exp_l;
      exp_l = (n >= GAP) ? 1 : 0;
      cyc(1'b1, 1'b0);
      for (int q = 0; q < n; q++) cyc(1'b0, 1'b0);
      chk("R7 quiet no window", fast_start, 0);
      cyc(n % 2 == 1, n % 2 == 0);
      chk(exp_l ? "R5 R6 gap launch" : "R7 short gap", fast_start, exp_l);
      chk(exp_l ? "R6 resync" : "R7 no resync", resync, exp_l);
      chk("R8 dg cleared by launch", data_good, 1 - exp_l);
      zeros(1);
      chk("R6 resync one cycle", resync, 0);
      zeros(FS + 2);
      chk("R8 dg after window", data_good, 1);
    end

    // Relaunch inside a window restarts length.
    rd_cmd = 1'b0;
    zeros(2);
    rd_cmd = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R8 dg cleared by cmd", data_good, 0);
    rd_cmd = 1'b0;
    zeros(4);
    rd_cmd = 1'b1;
    cyc(1'b1, 1'b0);
    begin
      int hi = 1;
      for (int i = 0; i < FS + 5; i++) begin
        cyc(i % 2 == 1, 1'b0);
        if (fast_start) hi++;
        else break;
      end
      chk("R2 restart length", hi, FS);
    end

    // Read enable drop.
    rd_cmd = 1'b0;
    cyc(1'b0, 1'b0);
    rd_cmd = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R2 fs on", fast_start, 1);
    rd_en = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R9 drop fast_start", fast_start, 0);
    chk("R9 drop data_good", data_good, 0);
    rd_cmd = 1'b0;
    cyc(1'b0, 1'b0);
    rd_cmd = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R9 cmd ignored while disabled", fast_start, 0);
    rd_en = 1'b1;
    for (int i = 0; i < GAP - 1; i++) cyc(1'b0, 1'b0);
    chk("R9 held cmd no window", fast_start, 0);
    cyc(1'b0, 1'b1);
    chk("R9 R7 count from rd_en rise", fast_start, 0);
    for (int i = 0; i < GAP; i++) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    chk("R5 R10 late pulse launch", fast_start, 1);
    chk("R6 resync late", resync, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule